// File: doc/BRIEF.md
# Digit-Serial Adder

This block adds two binary operands that arrive over several clock cycles, a fixed-width digit at a time, lowest digit first. Each cycle one digit of each operand enters. A small ripple chain adds the two digits and a carry-in. The sum digit leaves in the same cycle, and the carry out is held in a single flip-flop so that it can feed the next digit.

A `start` strobe on the first digit of a new operand pair replaces the held carry with an external initial carry in that same cycle. Because of this, one addition can follow another on the very next cycle, with no idle cycle between them. An idle cycle (`validIn` low) leaves the held carry unchanged, so gaps inside a stream are harmless. When the digit width is set to one, the block becomes a bit-serial adder: one full adder and one carry flip-flop.

Top module: `digit_serial_add`

## Requirements
- R1: When `start` is low, `{carryOut, sumDigit}` equals `xDigit + yDigit + storedCarry` in the same cycle. `carryOut` is the most significant bit of that sum.
- R2: On a cycle with `validIn` high, the stored carry takes the value of `carryOut` at the next rising clock edge.
- R3: On a cycle with `validIn` low, the stored carry keeps its value, and the digit inputs and `start` of that cycle have no effect on later digits.
- R4: When `start` is high, the carry into the digit is `carryInit` and the stored carry is ignored. `carryInit` has no effect on any cycle where `start` is low.
- R5: A synchronous, active-high `rst` clears the stored carry to 0.
- R6: `validOut` equals `validIn` in the same cycle.
- R7: A stream of digits starting with `start` produces, in order, the digits of `x + y + carryInit` modulo 2^(digits×DIGIT_W). The `carryOut` of the last digit is the final carry. Consecutive streams may follow one another on back-to-back cycles.
- R8: With `DIGIT_W = 1`, the block behaves as a bit-serial adder that satisfies R1 to R7 one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | The current digit is part of a stream |
| start | input | 1 | The current digit is the lowest digit of a new operand pair |
| carryInit | input | 1 | Initial carry, used when `start` is high |
| xDigit | input | DIGIT_W | Digit of the first operand |
| yDigit | input | DIGIT_W | Digit of the second operand |
| sumDigit | output | DIGIT_W | Sum digit |
| carryOut | output | 1 | Carry out of the current digit |
| validOut | output | 1 | Mirrors `validIn` |

## Verification
A wrong stored carry appears at the ports in the cycle after it is stored: the next digit's lowest sum bit, and possibly its carry, is off by one. A reassembled sum therefore shows the error at the digit that follows the bad update. A carry that leaks across a `start` boundary, or across a reset, corrupts only the first digit of the next stream. That is why the bench runs streams back to back and gives the first digit after a reset zero operands. A carry lost or picked up during an idle cycle is caught by streams that contain gaps.

// File: rtl/dsadd_pkg.sv
package dsadd_pkg;
  typedef struct packed {
    logic useInit;   // take the external initial carry this cycle
    logic carryWe;   // capture carry out at the next edge
  } dsaddStrobes_t;
endpackage

// File: rtl/dsadd_ripple.sv
module dsadd_ripple #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             cIn,
  output logic [WIDTH-1:0] sOut,
  output logic             cOut
);
  logic [WIDTH:0] chain;
  assign chain[0] = cIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic p;
    assign p          = aIn[i] ^ bIn[i];
    assign sOut[i]    = p ^ chain[i];
    assign chain[i+1] = (aIn[i] & bIn[i]) | (p & chain[i]);
  end

  assign cOut = chain[WIDTH];
endmodule

// File: rtl/dsadd_ctrl.sv
module dsadd_ctrl
  import dsadd_pkg::*;
(
  input  logic          start,
  input  logic          validIn,
  output dsaddStrobes_t strobes,
  output logic          validOut
);
  always_comb begin
    strobes.useInit = start;
    strobes.carryWe = validIn;
  end
  assign validOut = validIn;
endmodule

// File: rtl/dsadd_datapath.sv
module dsadd_datapath
  import dsadd_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  dsaddStrobes_t      strobes,
  input  logic               carryInit,
  input  logic [DIGIT_W-1:0] xDigit,
  input  logic [DIGIT_W-1:0] yDigit,
  output logic [DIGIT_W-1:0] sumDigit,
  output logic               carryOut
);
  localparam int SW = DIGIT_W + 1;

  logic carryReg;
  logic carryIn;

  assign carryIn = strobes.useInit ? carryInit : carryReg;

  dsadd_ripple #(.WIDTH(DIGIT_W)) u_ripple (
    .aIn (xDigit),
    .bIn (yDigit),
    .cIn (carryIn),
    .sOut(sumDigit),
    .cOut(carryOut)
  );

  always_ff @(posedge clk) begin
    if (rst)                  carryReg <= 1'b0;
    else if (strobes.carryWe) carryReg <= carryOut;
  end

  assert_digit_sum_R1: assert property (@(posedge clk) disable iff (rst)
    !strobes.useInit |->
      (({1'b0, xDigit} + {1'b0, yDigit} + SW'(carryReg)) == {carryOut, sumDigit}));

  assert_carry_capture_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.carryWe |=> (carryReg == $past(carryOut)));

  assert_carry_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !strobes.carryWe |=> $stable(carryReg));

  assert_init_select_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.useInit |->
      (({1'b0, xDigit} + {1'b0, yDigit} + SW'(carryInit)) == {carryOut, sumDigit}));
endmodule

// File: rtl/digit_serial_add.sv
module digit_serial_add
  import dsadd_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               validIn,
  input  logic               start,
  input  logic               carryInit,
  input  logic [DIGIT_W-1:0] xDigit,
  input  logic [DIGIT_W-1:0] yDigit,
  output logic [DIGIT_W-1:0] sumDigit,
  output logic               carryOut,
  output logic               validOut
);
  dsaddStrobes_t strobes;

  dsadd_ctrl u_ctrl (
    .start   (start),
    .validIn (validIn),
    .strobes (strobes),
    .validOut(validOut)
  );

  dsadd_datapath #(.DIGIT_W(DIGIT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .carryInit(carryInit),
    .xDigit   (xDigit),
    .yDigit   (yDigit),
    .sumDigit (sumDigit),
    .carryOut (carryOut)
  );
endmodule

// File: tb/sim_digit_serial_add.sv
`timescale 1ns/1ps
module sim_digit_serial_add;
  localparam int W = 4;
  localparam int NDIG = 4;
  localparam int OPW = W * NDIG;

  typedef struct packed {
    logic [OPW-1:0] xa;
    logic [OPW-1:0] ya;
    logic           c0;
    logic [OPW:0]   exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0001, 16'h0001, 1'b0, 17'h00002},
    '{16'hFFFF, 16'h0001, 1'b0, 17'h10000},
    '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    '{16'h1234, 16'h4321, 1'b0, 17'h05555},
    '{16'h8000, 16'h8000, 1'b1, 17'h10001},
    '{16'h0F0F, 16'h00F1, 1'b0, 17'h01000},
    '{16'hABCD, 16'h5432, 1'b1, 17'h10000},
    '{16'h0000, 16'h0000, 1'b1, 17'h00001}
  };

  logic clk = 1'b0;
  logic rst, validIn, start, carryInit;
  logic [W-1:0] xDigit, yDigit, sumDigit;
  logic carryOut, validOut;

  logic rst1, validIn1, start1, carryInit1;
  logic xBit, yBit, sumBit, carryOut1, validOut1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  digit_serial_add #(.DIGIT_W(W)) u0 (
    .clk(clk), .rst(rst), .validIn(validIn), .start(start), .carryInit(carryInit),
    .xDigit(xDigit), .yDigit(yDigit), .sumDigit(sumDigit), .carryOut(carryOut),
    .validOut(validOut)
  );

  digit_serial_add #(.DIGIT_W(1)) u1 (
    .clk(clk), .rst(rst1), .validIn(validIn1), .start(start1), .carryInit(carryInit1),
    .xDigit(xBit), .yDigit(yBit), .sumDigit(sumBit), .carryOut(carryOut1),
    .validOut(validOut1)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one stream of NDIG digits; optional idle cycle before each later digit.
  task automatic streamAdd(input logic [OPW-1:0] xa, input logic [OPW-1:0] ya,
                           input logic c0, input bit gaps, output logic [OPW:0] res);
    for (int d = 0; d < NDIG; d++) begin
      if (gaps && d > 0) begin
        @(negedge clk);
        validIn = 1'b0; start = 1'b0; carryInit = ~c0;
        xDigit = W'($urandom); yDigit = W'($urandom);
      end
      @(negedge clk);
      validIn   = 1'b1;
      start     = (d == 0);
      carryInit = (d == 0) ? c0 : ~c0;
      xDigit    = xa[d*W +: W];
      yDigit    = ya[d*W +: W];
      #1;
      res[d*W +: W] = sumDigit;
      if (d == NDIG - 1) res[OPW] = carryOut;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [OPW:0] got;
    logic [OPW:0] ref_;
    logic [OPW-1:0] rx, ry;
    logic rc;
    logic [8:0] bitRes;

    rst = 1'b1; validIn = 1'b0; start = 1'b0; carryInit = 1'b0;
    xDigit = '0; yDigit = '0;
    rst1 = 1'b1; validIn1 = 1'b0; start1 = 1'b0; carryInit1 = 1'b0;
    xBit = 1'b0; yBit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; rst1 = 1'b0;

    // R5: the stored carry is 0 after reset (0+0 with start low gives 0; F+0 gives F, no carry)
    #1;
    chk(sumDigit == 4'h0 && carryOut == 1'b0, "R5 reset carry zero", {sumDigit, carryOut}, 0);
    xDigit = 4'hF; #1;
    chk(sumDigit == 4'hF && carryOut == 1'b0, "R5 reset carry zero F", {sumDigit, carryOut}, {4'hF, 1'b0});
    // R6: validOut follows validIn
    chk(validOut == 1'b0, "R6 validOut low", validOut, 0);
    validIn = 1'b1; #1;
    chk(validOut == 1'b1, "R6 validOut high", validOut, 1);
    // R1/R4: single digit with start: 7+8+1 = 0x10
    start = 1'b1; carryInit = 1'b1; xDigit = 4'h7; yDigit = 4'h8; #1;
    chk(sumDigit == 4'h0 && carryOut == 1'b1, "R4 start takes carryInit", {sumDigit, carryOut}, {4'h0, 1'b1});
    // R2: that carry (1) is stored; next digit 2+3 with start low gives 6
    @(negedge clk);
    start = 1'b0; carryInit = 1'b0; xDigit = 4'h2; yDigit = 4'h3; #1;
    chk(sumDigit == 4'h6 && carryOut == 1'b0, "R2 stored carry used R1", {sumDigit, carryOut}, {4'h6, 1'b0});
    // R4: start ignores a stored carry of 1: store 1 via F+1, then start with carryInit 0
    @(negedge clk);
    xDigit = 4'hF; yDigit = 4'h1;
    @(negedge clk);
    start = 1'b1; carryInit = 1'b0; xDigit = 4'h4; yDigit = 4'h4; #1;
    chk(sumDigit == 4'h8 && carryOut == 1'b0, "R4 stored carry ignored", {sumDigit, carryOut}, {4'h8, 1'b0});
    // R3: idle cycle with start and carry-producing inputs leaves the stored carry (0)
    @(negedge clk);
    validIn = 1'b0; start = 1'b1; carryInit = 1'b1; xDigit = 4'hF; yDigit = 4'hF;
    @(negedge clk);
    validIn = 1'b1; start = 1'b0; xDigit = 4'h1; yDigit = 4'h0; #1;
    chk(sumDigit == 4'h1 && carryOut == 1'b0, "R3 idle cycle no effect", {sumDigit, carryOut}, {4'h1, 1'b0});

    // R7: table of streams, back to back, no gaps
    for (int v = 0; v < NVEC; v++) begin
      streamAdd(VECS[v].xa, VECS[v].ya, VECS[v].c0, 1'b0, got);
      chk(got == VECS[v].exp, "R7 table stream", 32'(got), 32'(VECS[v].exp));
    end

    // R3/R7: random streams with idle gaps, and random back-to-back streams
    for (int k = 0; k < 40; k++) begin
      rx = OPW'($urandom); ry = OPW'($urandom); rc = 1'($urandom);
      ref_ = {1'b0, rx} + {1'b0, ry} + (OPW+1)'(rc);
      streamAdd(rx, ry, rc, (k % 2) == 1, got);
      chk(got == ref_, (k % 2) ? "R3 gapped stream" : "R7 random stream",
          32'(got), 32'(ref_));
    end

    // R5: reset mid-stream with a stored carry of 1
    @(negedge clk);
    validIn = 1'b1; start = 1'b1; carryInit = 1'b1; xDigit = 4'hF; yDigit = 4'hF;
    @(negedge clk);
    rst = 1'b1; validIn = 1'b0; start = 1'b0;
    @(negedge clk);
    rst = 1'b0; validIn = 1'b1; xDigit = 4'h0; yDigit = 4'h0; #1;
    chk(sumDigit == 4'h0 && carryOut == 1'b0, "R5 mid-stream reset", {sumDigit, carryOut}, 0);

    // R8: bit-serial instance, 0xB5 + 0x6E + 0 = 0x123, then 0xFF + 0x00 + 1 = 0x100
    for (int s = 0; s < 2; s++) begin
      logic [7:0] ax, ay;
      logic       ac;
      logic [8:0] eb;
      ax = (s == 0) ? 8'hB5 : 8'hFF;
      ay = (s == 0) ? 8'h6E : 8'h00;
      ac = (s == 1);
      eb = (s == 0) ? 9'h123 : 9'h100;
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        validIn1 = 1'b1; start1 = (b == 0); carryInit1 = (b == 0) ? ac : ~ac;
        xBit = ax[b]; yBit = ay[b];
        #1;
        bitRes[b] = sumBit;
        if (b == 7) bitRes[8] = carryOut1;
      end
      chk(bitRes == eb, "R8 bit-serial stream", 32'(bitRes), 32'(eb));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule